// File: doc/BRIEF.md
# Add/Subtract ALU with Status Flags

This block is a purely combinational arithmetic and logic unit for 32-bit operands. A 3-bit operation code selects one of four bitwise logical functions, addition, subtraction, or a signed less-than comparison. It returns a 32-bit result together with a carry-out, a signed overflow flag, a zero flag and a sign flag.

A single carry chain serves both addition and subtraction. For subtraction and comparison, the second operand passes through XOR gates driven by a subtract control, and the same control feeds the carry-in of the lowest bit. Signed overflow is computed from the operand and result sign bits, with separate rules for add and for subtract. Both the comparison and the sign flag combine the raw sign bit with that overflow, so they remain correct when the difference wraps.

The block is meant to sit in an execute stage next to a separate shifter. It has no clock and no state.

Top module: `alu_addsub`

## Requirements
- R1: With op_sel = 3'b010 (add), result is the low 32 bits of a_in + b_in taken as unsigned, and carry_out is the carry out of bit 31.
- R2: With op_sel = 3'b110 (subtract), result is a_in - b_in modulo 2^32, and carry_out is the carry out of a_in + ~b_in + 1. It is therefore 1 exactly when a_in >= b_in as unsigned values.
- R3: For add, ovf is 1 exactly when both operands have bit 31 clear and the result has bit 31 set, or when both operands have bit 31 set and the result has bit 31 clear.
- R4: For subtract and set-less-than (op_sel = 3'b111), ovf is 1 exactly when a_in[31]=0, b_in[31]=1 and the difference is negative, or when a_in[31]=1, b_in[31]=0 and the difference is non-negative.
- R5: zero is 1 exactly when all 32 result bits are 0, for every operation code.
- R6: The logical codes act bit by bit on all 32 bits: 3'b000 AND, 3'b001 OR, 3'b011 XOR, 3'b100 NOR.
- R7: With op_sel = 3'b111, result bit 0 is 1 exactly when a_in < b_in as signed two's complement values (the sign of a_in - b_in XOR the subtract overflow), and bits 31..1 are 0. This holds even when the difference overflows.
- R8: For the logical codes and for the unused code 3'b101, carry_out and ovf are 0. Code 3'b101 gives a result of all zeros.
- R9: neg gives the sign of the mathematically exact result. For add and subtract it is result bit 31 XOR ovf. For set-less-than it equals the less-than bit. For logical codes it is result bit 31, and for code 3'b101 it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_in | input | 32 | First operand |
| b_in | input | 32 | Second operand |
| op_sel | input | 3 | Operation code |
| result | output | 32 | Operation result |
| carry_out | output | 1 | Carry out of the most significant bit |
| ovf | output | 1 | Signed overflow |
| zero | output | 1 | Result is all zeros |
| neg | output | 1 | Sign of the exact result |

## Verification
Random operand pairs are used for every operation code, including the unused one, to separate the logical functions from each other and from the arithmetic path. Directed pairs drive the adder to the boundaries where sign and carry split apart:
- the most positive and most negative values against each other and against one;
- all-ones plus one, where carry is set but signed overflow is not;
- equal operands, which yield a zero difference.

For the comparison, directed pairs whose difference wraps (most negative minus a positive value, a positive value minus the most negative) expose a design that uses the raw sign bit instead of the corrected one.

// File: rtl/alu_addsub.sv
module alu_addsub #(
  parameter int W = 32
) (
  input  logic [W-1:0] a_in,
  input  logic [W-1:0] b_in,
  input  logic [2:0]   op_sel,
  output logic [W-1:0] result,
  output logic         carry_out,
  output logic         ovf,
  output logic         zero,
  output logic         neg
);
  localparam int M = W - 1;
  localparam logic [2:0] OP_AND = 3'b000, OP_OR = 3'b001, OP_ADD = 3'b010, OP_XOR = 3'b011,
                         OP_NOR = 3'b100, OP_SUB = 3'b110, OP_SLT = 3'b111;

  logic         sub_en;
  logic [W-1:0] b_eff, sum;
  logic [W:0]   cy;
  logic         ovf_add, ovf_sub, lt;

  assign sub_en = op_sel[2] & op_sel[1];
  assign b_eff  = b_in ^ {W{sub_en}};
  assign cy[0]  = sub_en;

  for (genvar i = 0; i < W; i++) begin : g_fa
    assign sum[i]  = a_in[i] ^ b_eff[i] ^ cy[i];
    assign cy[i+1] = (a_in[i] & b_eff[i]) | (cy[i] & (a_in[i] ^ b_eff[i]));
  end

  assign ovf_add = (~a_in[M] & ~b_in[M] & sum[M]) | (a_in[M] & b_in[M] & ~sum[M]);
  assign ovf_sub = (~a_in[M] & b_in[M] & sum[M]) | (a_in[M] & ~b_in[M] & ~sum[M]);
  assign lt      = sum[M] ^ ovf_sub;

  always_comb begin
    result    = '0;
    carry_out = 1'b0;
    ovf       = 1'b0;
    neg       = 1'b0;
    case (op_sel)
      OP_AND: result = a_in & b_in;
      OP_OR:  result = a_in | b_in;
      OP_XOR: result = a_in ^ b_in;
      OP_NOR: result = ~(a_in | b_in);
      OP_ADD: begin
        result = sum; carry_out = cy[W]; ovf = ovf_add; neg = sum[M] ^ ovf_add;
      end
      OP_SUB: begin
        result = sum; carry_out = cy[W]; ovf = ovf_sub; neg = sum[M] ^ ovf_sub;
      end
      OP_SLT: begin
        result = {{M{1'b0}}, lt}; carry_out = cy[W]; ovf = ovf_sub; neg = lt;
      end
      default: ;
    endcase
    if (op_sel[1:0] != 2'b10 && op_sel != OP_SUB && op_sel != OP_SLT && op_sel != 3'b101)
      neg = result[M];
  end

  assign zero = ~|result;

  always_comb begin
    if (op_sel == OP_ADD)
      AST_ADD_SUM: assert ({carry_out, result} == {1'b0, a_in} + {1'b0, b_in}); // R1
    if (op_sel == OP_SUB)
      AST_SUB_BORROW: assert (carry_out == (a_in >= b_in)); // R2
    if (op_sel == OP_SUB && zero)
      AST_SUB_ZERO_EQ: assert (a_in == b_in); // R5
    if (op_sel == OP_SLT)
      AST_SLT_SIGNED: assert (result == {{M{1'b0}}, ($signed(a_in) < $signed(b_in))}); // R7
    if (op_sel == 3'b000 || op_sel == 3'b001 || op_sel == 3'b011 || op_sel == 3'b100 || op_sel == 3'b101)
      AST_LOGIC_NO_FLAGS: assert (!carry_out && !ovf); // R8
    if (op_sel == OP_ADD && a_in[M] != b_in[M])
      AST_ADD_MIXED_NO_OVF: assert (!ovf); // R3
    if (op_sel == OP_SUB && a_in[M] == b_in[M])
      AST_SUB_SAME_NO_OVF: assert (!ovf); // R4
  end
endmodule

// File: tb/test_alu_addsub.sv
module test_alu_addsub;
  localparam int W = 32;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic [W-1:0] a_in, b_in, result;
  logic [2:0]   op_sel;
  logic         carry_out, ovf, zero, neg;
  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  alu_addsub #(.W(W)) i_alu_addsub (.a_in(a_in), .b_in(b_in), .op_sel(op_sel), .result(result),
    .carry_out(carry_out), .ovf(ovf), .zero(zero), .neg(neg));

  task automatic cmp(input string tag, input string what, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s op=%b a=%h b=%h actual=%h expected=%h", tag, what, op_sel, a_in, b_in, act, exp);
    end
  endtask

  task automatic run(input logic [2:0] op, input logic [W-1:0] a, input logic [W-1:0] b);
    logic [W-1:0] e_res; logic e_c, e_v, e_n; longint ex; string tr, tc, tv;
    longint sa, sb;
    @(posedge clk);
    op_sel = op; a_in = a; b_in = b;
    sa = longint'($signed(a)); sb = longint'($signed(b));
    e_res = '0; e_c = 0; e_v = 0; e_n = 0; tc = "R8"; tv = "R8"; tr = "R6";
    case (op)
      3'b000: e_res = a & b;
      3'b001: e_res = a | b;
      3'b011: e_res = a ^ b;
      3'b100: e_res = ~(a | b);
      3'b010: begin
        {e_c, e_res} = {1'b0, a} + {1'b0, b}; ex = sa + sb;
        e_v = (ex > 64'sh7fffffff) || (ex < -64'sh80000000); e_n = ex < 0;
        tr = "R1"; tc = "R1"; tv = "R3";
      end
      3'b110, 3'b111: begin
        e_res = a - b; e_c = (a >= b); ex = sa - sb;
        e_v = (ex > 64'sh7fffffff) || (ex < -64'sh80000000); e_n = ex < 0;
        tr = "R2"; tc = "R2"; tv = "R4";
        if (op == 3'b111) begin e_res = {31'd0, (sa < sb)}; e_n = sa < sb; tr = "R7"; end
      end
      default: tr = "R8";
    endcase
    if (op inside {3'b000, 3'b001, 3'b011, 3'b100}) e_n = e_res[W-1];
    @(negedge clk);
    cmp(tr, "result", result, e_res);
    cmp(tc, "carry", {31'd0, carry_out}, {31'd0, e_c});
    cmp(tv, "ovf", {31'd0, ovf}, {31'd0, e_v});
    cmp("R5", "zero", {31'd0, zero}, {31'd0, (e_res == '0)});
    cmp("R9", "neg", {31'd0, neg}, {31'd0, e_n});
  endtask

  initial begin
    #20000000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] dir [8];
    void'($urandom(32'd12345));
    op_sel = 3'b000; a_in = '0; b_in = '0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    cmp("R5", "reset-zero", {31'd0, zero}, 32'd1);
    cmp("R8", "reset-carry", {31'd0, carry_out}, 32'd0);
    dir = '{32'h0, 32'h1, 32'h7fffffff, 32'h80000000, 32'hffffffff, 32'h80000001, 32'h7ffffffe, 32'h12345678};
    for (int op = 0; op < 8; op++)
      for (int i = 0; i < 8; i++)
        for (int j = 0; j < 8; j++)
          run(3'(op), dir[i], dir[j]);
    run(3'b111, 32'h80000000, 32'h00000001);  // R7 wrap, expect 1
    run(3'b111, 32'h7fffffff, 32'hffffffff);  // R7 wrap, expect 0
    run(3'b010, 32'hffffffff, 32'h00000001);  // R1 carry without R3 overflow
    run(3'b110, 32'hdeadbeef, 32'hdeadbeef);  // R5 zero difference
    for (int k = 0; k < 3000; k++)
      run(3'($urandom_range(7)), $urandom, $urandom);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule